// File: doc/BRIEF.md
# Half-Duplex Frame Transmit Handshake Controller

This controller sits on the host side of a byte-wide buffered write link to a baseband transmitter that shares a half-duplex medium. When the host requests a frame, the controller waits until the medium is idle and no reception is in progress. It then raises a transmit-enable line and waits for the device to accept by asserting carrier sense. After that it moves the frame's bytes from a valid/ready byte source onto the byte bus, one byte per generated write strobe. When the byte count reaches the supplied frame length, it drops transmit-enable.

Carrier sense and receive-valid each pass through a debounce filter, so a level must be stable for a set number of clocks before the controller acts on it. Each byte is placed on the bus one clock before the strobe rises and is kept there one clock after the strobe falls. A length of zero is refused with an error pulse. If the device does not accept a request within a number of cycles set per frame, the attempt is abandoned with a timeout pulse.

Top module: `frame_tx_ctrl`

## Requirements
- R1: With `start_i` high and a non-zero length, `txen_o` rises only once the debounced carrier sense is low. When `crs_i` falls while a request is pending, `txen_o` is first seen high on the fourth clock after the fall (debounce of 3, plus one state register).
- R2: While the debounced receive-valid is high, no transmission starts. Once `rxdv_i` falls, the same four-clock start delay as in R1 applies.
- R3: After `txen_o` rises, no write strobe is issued until the debounced carrier sense is high.
- R4: A carrier-sense pulse shorter than DEB_LEN (default 3) clocks is ignored: no strobe follows it and `txen_o` stays high.
- R5: Each frame produces exactly `frame_len_i` write-strobe pulses, each one clock wide. The bytes appear on `dat_o` in the order the source supplied them.
- R6: `dat_o` holds the same value in the clock before, during and after every cycle in which `wr_o` is high.
- R7: While the byte source is not valid, no strobe is issued and the byte count does not advance, so a stalled source loses and duplicates no byte.
- R8: `txen_o` falls in the clock after the final strobe, and `done_o` pulses in that same clock. No new frame starts, even with `start_i` held high, until the debounced carrier sense is low again.
- R9: A request with `frame_len_i` = 0 leaves `txen_o` low and raises `len_err_o` for one clock, one clock after the request.
- R10: If carrier sense is not seen, `txen_o` stays high for exactly `tmo_cycles_i` clocks (value latched at start, minimum 1). It then falls with a one-clock `tmo_o` pulse and no strobe. If the debounced carrier sense arrives in the last allowed clock, the frame proceeds and no timeout is signalled.
- R11: After reset, `txen_o`, `wr_o`, `byte_ready_o`, `busy_o`, `done_o`, `len_err_o` and `tmo_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, held until `txen_o` rises |
| frame_len_i | input | LEN_W | Frame length in bytes, latched at start |
| tmo_cycles_i | input | TMO_W | Accept timeout in clocks, latched at start |
| byte_i | input | 8 | Source byte |
| byte_valid_i | input | 1 | Source byte valid |
| byte_ready_o | output | 1 | Byte taken when high together with valid |
| crs_i | input | 1 | Carrier sense from the device |
| rxdv_i | input | 1 | Receive-valid from the device |
| txen_o | output | 1 | Transmit enable |
| wr_o | output | 1 | Byte write strobe |
| dat_o | output | 8 | Byte bus |
| busy_o | output | 1 | Controller is not idle |
| done_o | output | 1 | One-clock pulse at frame end |
| len_err_o | output | 1 | One-clock pulse for a zero-length request |
| tmo_o | output | 1 | One-clock pulse for an accept timeout |

## Verification
Two functions can fall in the same clock: expiry of the accept timeout and arrival of the debounced carrier sense. The bench raises `crs_i` in the first clock that shows `txen_o`, so the debounced value arrives in the fourth request clock. It runs this once with a limit of 4 and once with a limit of 3. With the limit of 4, the frame must complete with no timeout pulse. With the limit of 3, the request must end after three clocks with one timeout pulse and no strobe.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    PH_TAKE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STB   = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/ftx_debounce.sv
module ftx_debounce #(
  parameter int unsigned LEN     = 3,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          clean_q;

  // output follows only after LEN consecutive samples of the new level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      clean_q <= RST_VAL;
    end else if (raw_i == clean_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(LEN - 1)) begin
      cnt_q   <= '0;
      clean_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/ftx_timer.sv
module ftx_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // expires in the lim-th running cycle; lim 0 behaves as 1
  assign expire_o = run_i && (({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ftx_byte_writer.sv
module ftx_byte_writer
  import ftx_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             wr_o,
  output logic [7:0]       dat_o,
  output logic             last_o
);
  wr_phase_e        phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [7:0]       dat_q;

  assign ready_o = en_i && (phase_q == PH_TAKE);
  assign wr_o    = en_i && (phase_q == PH_STB);
  assign last_o  = wr_o && (cnt_q == len_i - 1'b1);
  assign dat_o   = dat_q;

  // TAKE (hold of previous byte) -> SETUP -> STB; data changes only on leaving TAKE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_TAKE;
      cnt_q   <= '0;
      dat_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_TAKE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_TAKE;
    end else begin
      unique case (phase_q)
        PH_TAKE: if (valid_i) begin
          dat_q   <= byte_i;
          phase_q <= PH_SETUP;
        end
        PH_SETUP: phase_q <= PH_STB;
        PH_STB: begin
          cnt_q   <= cnt_q + 1'b1;
          phase_q <= PH_TAKE;
        end
        default: phase_q <= PH_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import ftx_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned TMO_W   = 16,
  parameter int unsigned DEB_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [TMO_W-1:0] tmo_cycles_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             crs_i,
  input  logic             rxdv_i,
  output logic             txen_o,
  output logic             wr_o,
  output logic [7:0]       dat_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             len_err_o,
  output logic             tmo_o
);
  localparam int unsigned N_STAT = 2;
  localparam int unsigned IDX_CRS  = 0;
  localparam int unsigned IDX_RXDV = 1;

  logic [N_STAT-1:0] stat_raw, stat_db;
  logic crs_db, rxdv_db;

  assign stat_raw[IDX_CRS]  = crs_i;
  assign stat_raw[IDX_RXDV] = rxdv_i;

  for (genvar g = 0; g < N_STAT; g++) begin : g_deb
    ftx_debounce #(.LEN(DEB_LEN), .RST_VAL(1'b0)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (stat_raw[g]),
      .clean_o(stat_db[g])
    );
  end

  assign crs_db  = stat_db[IDX_CRS];
  assign rxdv_db = stat_db[IDX_RXDV];

  ctl_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [TMO_W-1:0] tmo_lim_q;
  logic             launch, tmo_exp, wr_last;
  logic             done_d, err_d, tmo_d;
  logic             done_q, err_q, tmo_q;
  logic             medium_free;

  assign medium_free = !crs_db && !rxdv_db;

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (frame_len_i == '0) begin
          err_d = 1'b1;
        end else if (medium_free) begin
          launch  = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        // acceptance wins over expiry in the same cycle
        if (crs_db) begin
          state_d = ST_WRITE;
        end else if (tmo_exp) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: if (wr_last) begin
        done_d  = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: if (!crs_db) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      tmo_lim_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      tmo_q   <= tmo_d;
      if (launch) begin
        len_q     <= frame_len_i;
        tmo_lim_q <= tmo_cycles_i;
      end
    end
  end

  ftx_timer #(.W(TMO_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch),
    .run_i   ((state_q == ST_REQ) && !crs_db),
    .lim_i   (tmo_lim_q),
    .expire_o(tmo_exp)
  );

  ftx_byte_writer #(.LEN_W(LEN_W)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(launch),
    .en_i   (state_q == ST_WRITE),
    .len_i  (len_q),
    .byte_i (byte_i),
    .valid_i(byte_valid_i),
    .ready_o(byte_ready_o),
    .wr_o   (wr_o),
    .dat_o  (dat_o),
    .last_o (wr_last)
  );

  assign txen_o    = (state_q == ST_REQ) || (state_q == ST_WRITE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign len_err_o = err_q;
  assign tmo_o     = tmo_q;
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       txen_o,
  input logic       wr_o,
  input logic [7:0] dat_o,
  input logic       byte_ready_o,
  input logic       byte_valid_i,
  input logic       done_o,
  input logic       len_err_o,
  input logic       tmo_o,
  input logic       crs_db,
  input logic       rxdv_db
);
  // R1 R2
  a_r1_launch_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> $past(!crs_db && !rxdv_db));
  a_r3_no_early_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |=> !wr_o);
  a_r3_wr_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> txen_o);
  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  a_r6_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_o) |-> $stable(dat_o));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> $stable(dat_o));
  a_r7_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && !byte_valid_i) |=> !wr_o);
  a_r8_done_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!txen_o && $past(wr_o)));
  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> !txen_o);
  a_r10_tmo_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> (!txen_o && $past(txen_o) && !$past(wr_o)));
endmodule

bind frame_tx_ctrl ftx_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .txen_o      (txen_o),
  .wr_o        (wr_o),
  .dat_o       (dat_o),
  .byte_ready_o(byte_ready_o),
  .byte_valid_i(byte_valid_i),
  .done_o      (done_o),
  .len_err_o   (len_err_o),
  .tmo_o       (tmo_o),
  .crs_db      (crs_db),
  .rxdv_db     (rxdv_db)
);

// File: tb/tb_frame_tx_ctrl.sv
module tb_frame_tx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] frame_len = '0;
  logic [15:0] tmo_cycles = 16'd1000;
  logic [7:0]  byte_in;
  logic        byte_valid;
  logic        byte_ready;
  logic        crs = 1'b0;
  logic        rxdv = 1'b0;
  logic        txen, wr, busy, done, len_err, tmo;
  logic [7:0]  dat;

  int n_tests = 0;
  int n_fail  = 0;

  frame_tx_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_len_i(frame_len),
    .tmo_cycles_i(tmo_cycles), .byte_i(byte_in), .byte_valid_i(byte_valid),
    .byte_ready_o(byte_ready), .crs_i(crs), .rxdv_i(rxdv), .txen_o(txen),
    .wr_o(wr), .dat_o(dat), .busy_o(busy), .done_o(done),
    .len_err_o(len_err), .tmo_o(tmo)
  );

  always #4 clk = ~clk;

  // byte source
  logic [7:0] src [0:31];
  int  src_n = 0, src_idx = 0;
  bit  stall_mode = 1'b0;
  logic stall_tog = 1'b0;
  assign byte_valid = (src_idx < src_n) && (!stall_mode || stall_tog);
  assign byte_in    = src[src_idx[4:0]];
  always @(posedge clk) if (byte_valid && byte_ready) src_idx <= src_idx + 1;
  always @(negedge clk) stall_tog <= ~stall_tog;

  // device model
  bit auto_ack = 1'b0, crs_hold = 1'b0;
  int ack_cnt = 0, rel_cnt = 0;
  always @(negedge clk) begin
    if (auto_ack) begin
      if (txen && !crs) begin
        ack_cnt <= ack_cnt + 1;
        if (ack_cnt >= 2) crs <= 1'b1;
      end else ack_cnt <= 0;
      if (!txen && crs && !crs_hold) begin
        rel_cnt <= rel_cnt + 1;
        if (rel_cnt >= 1) crs <= 1'b0;
      end else rel_cnt <= 0;
    end
  end

  // monitor
  logic [7:0] cap [0:63];
  int ncap = 0, n_done = 0, n_err = 0, n_tmo = 0, setup_bad = 0, hold_bad = 0;
  logic [7:0] prev_dat = '0, held = '0;
  bit hold_pend = 1'b0;
  always @(negedge clk) begin
    if (wr) begin
      cap[ncap[5:0]] = dat;
      ncap++;
      if (dat !== prev_dat) setup_bad++;
      held = dat;
      hold_pend = 1'b1;
    end else if (hold_pend) begin
      if (dat !== held) hold_bad++;
      hold_pend = 1'b0;
    end
    prev_dat = dat;
    if (done)    n_done++;
    if (len_err) n_err++;
    if (tmo)     n_tmo++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; n_done = 0; n_err = 0; n_tmo = 0; setup_bad = 0; hold_bad = 0;
  endtask

  task automatic load_src(input int n, input int seed);
    for (int i = 0; i < 32; i++) src[i] = 8'(i * 29 + seed * 7 + 1);
    src_idx = 0;
    src_n = n;
  endtask

  task automatic wait_txen(output int k);
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      k++;
      if (txen) break;
    end
  endtask

  task automatic wait_caps(input int n);
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      if (ncap >= n) break;
    end
  endtask

  task automatic check_bytes(input int first, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[(first + i) % 64] !== src[first + i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!txen && !wr && !byte_ready && !busy && !done && !len_err && !tmo,
        "R11 reset outputs", {txen, wr, byte_ready, busy, done, len_err, tmo}, 0);
  endtask

  task automatic t_frame(input int n, input bit stall, input string tag);
    int k;
    clear_mon();
    load_src(n, n);
    stall_mode = stall;
    auto_ack = 1'b1;
    frame_len = 16'(n);
    tmo_cycles = 16'd1000;
    @(negedge clk);
    start = 1'b1;
    wait_txen(k);
    start = 1'b0;
    wait_caps(n);
    @(negedge clk);
    chk(!txen && done, {tag, " R8 txen drop and done after last strobe"}, {txen, done}, 1);
    check_bytes(0, n, {tag, " R5 byte order"});
    chk(setup_bad == 0 && hold_bad == 0, {tag, " R6 setup/hold"}, setup_bad + hold_bad, 0);
    repeat (12) @(negedge clk);
    chk(ncap == n, {tag, " R5/R7 strobe count"}, ncap, n);
    chk(!busy && n_done == 1, {tag, " R8 back to idle"}, n_done, 1);
    stall_mode = 1'b0;
  endtask

  task automatic t_medium_busy(input bit use_rx);
    int k;
    int seen = 0;
    clear_mon();
    load_src(3, 5);
    auto_ack = 1'b0;
    frame_len = 16'd3;
    tmo_cycles = 16'd1000;
    @(negedge clk);
    if (use_rx) rxdv = 1'b1; else crs = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (txen) seen++;
    end
    chk(seen == 0, use_rx ? "R2 rxdv blocks start" : "R1 crs blocks start", seen, 0);
    if (use_rx) rxdv = 1'b0; else crs = 1'b0;
    wait_txen(k);
    chk(k == 4, use_rx ? "R2 start delay after rxdv fall" : "R1 start delay after crs fall", k, 4);
    start = 1'b0;
    auto_ack = 1'b1;
    wait_caps(3);
    repeat (12) @(negedge clk);
    check_bytes(0, 3, use_rx ? "R2 frame after rxdv" : "R1 frame after crs");
  endtask

  task automatic t_glitch();
    int k;
    clear_mon();
    load_src(2, 9);
    auto_ack = 1'b0;
    crs = 1'b0;
    frame_len = 16'd2;
    tmo_cycles = 16'd1000;
    @(negedge clk);
    start = 1'b1;
    wait_txen(k);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(ncap == 0 && txen, "R3 no strobe before carrier sense", ncap, 0);
    crs = 1'b1;
    repeat (2) @(negedge clk);
    crs = 1'b0;
    repeat (6) @(negedge clk);
    chk(ncap == 0 && txen, "R4 short crs pulse ignored", ncap, 0);
    auto_ack = 1'b1;
    wait_caps(2);
    repeat (12) @(negedge clk);
    chk(ncap == 2, "R4 frame after real crs", ncap, 2);
    check_bytes(0, 2, "R4 bytes after real crs");
  endtask

  task automatic t_len0();
    clear_mon();
    frame_len = 16'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(len_err && !txen, "R9 zero length error pulse", {len_err, txen}, 2);
    @(negedge clk);
    chk(!len_err && !txen && !busy, "R9 error lasts one clock", {len_err, txen}, 0);
    repeat (5) @(negedge clk);
    chk(n_err == 1 && ncap == 0, "R9 single error, no write", n_err, 1);
  endtask

  task automatic t_timeout(input int lim);
    int hi = 0;
    clear_mon();
    load_src(0, 1);
    auto_ack = 1'b0;
    crs = 1'b0;
    frame_len = 16'd4;
    tmo_cycles = 16'(lim);
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (txen) begin start = 1'b0; hi++; end
      else if (hi > 0) break;
    end
    repeat (3) @(negedge clk);
    chk(hi == lim, "R10 txen length on timeout", hi, lim);
    chk(n_tmo == 1 && ncap == 0 && !busy, "R10 timeout pulse, no strobe", n_tmo, 1);
  endtask

  // carrier arrives exactly in the last allowed request clock
  task automatic t_race(input int lim);
    int k;
    clear_mon();
    load_src(2, 3);
    auto_ack = 1'b0;
    crs = 1'b0;
    frame_len = 16'd2;
    tmo_cycles = 16'(lim);
    @(negedge clk);
    start = 1'b1;
    wait_txen(k);
    start = 1'b0;
    crs = 1'b1;
    if (lim == 4) begin
      auto_ack = 1'b1;
      wait_caps(2);
      repeat (12) @(negedge clk);
      chk(n_tmo == 0 && ncap == 2, "R10 carrier wins tie with expiry", n_tmo, 0);
    end else begin
      repeat (8) @(negedge clk);
      chk(n_tmo == 1 && ncap == 0 && !txen, "R10 expiry one clock before carrier", n_tmo, 1);
      crs = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic t_back_to_back();
    int k;
    int seen = 0;
    clear_mon();
    load_src(6, 4);
    auto_ack = 1'b1;
    crs_hold = 1'b1;
    frame_len = 16'd3;
    tmo_cycles = 16'd1000;
    @(negedge clk);
    start = 1'b1;
    wait_caps(3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (txen) seen++;
    end
    chk(seen == 0, "R8 no restart while crs high", seen, 0);
    crs_hold = 1'b0;
    wait_txen(k);
    chk(txen, "R8 restart after crs low", txen, 1);
    start = 1'b0;
    wait_caps(6);
    repeat (12) @(negedge clk);
    chk(ncap == 6 && n_done == 2, "R8 two frames", ncap, 6);
    check_bytes(0, 6, "R5 bytes across two frames");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame(4, 1'b0, "basic");
    t_frame(1, 1'b0, "single");
    t_frame(7, 1'b1, "R7 stall");
    t_medium_busy(1'b0);
    t_medium_busy(1'b1);
    t_glitch();
    t_len0();
    t_timeout(10);
    t_timeout(1);
    t_race(4);
    t_race(3);
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule